// File: doc/BRIEF.md
# USART Register and Status Front End

This block is the software-visible side of a serial port. A 32-bit register bus reaches seven registers in a 0x400-byte address window. Two of them have side effects. The status register holds the receive-full, transmit-empty and transfer-done flags. The data register returns the last received byte on a read, and on a write it launches a byte towards the transmitter. The other five registers are control, baud and guard-time storage that the serialiser around this block uses.

Received bytes arrive on a valid/ready byte stream. The block holds a single byte and pushes back on the stream while that byte is unread. Transmit bytes leave on a one-cycle valid pulse. One level interrupt combines the flags with the enable bits in the first control register.

The bus read data is combinational from the address in the cycle that the read strobe is high. Read and write side effects take effect at the clock edge that ends that cycle.

Top module: `usart_regfile`

## Requirements
- R1: `irq` is high exactly when the status register ANDed with control register 1 has a 1 in bit 5, 6 or 7. It follows the register contents in the cycle after any change to either register.
- R2: `rx_ready` is high exactly while status bit 5 (receive-full) is 0. While that bit is 1, the held data byte is not overwritten by the stream.
- R3: A byte handed over on the stream while control register 1 bit 13 (port enable) or bit 2 (receive enable) is 0 is consumed and discarded. The status and data registers keep their values.
- R4: A byte handed over while both enables are 1 is loaded into the data register, and status bit 5 is set at the same edge.
- R5: A read of the data register (offset 0x04) returns its content masked to the low 10 bits and clears status bit 5.
- R6: A status write (offset 0x00) of a value of 0x3FF or less replaces the status register with that value ORed with 0x80 (bit 7, transmit-empty). A larger value is ANDed into the current status.
- R7: A data register write of a value below 0xF000 raises `tx_valid` for one cycle after the write edge, with `tx_data` equal to the low byte, and sets status bit 6 (transfer-done). A write of 0xF000 or more produces no beat and changes no flag.
- R8: After reset, the status register reads 0x000000C0, every other register reads 0, `irq` is 0 and `tx_valid` is 0.
- R9: The offsets 0x08 (baud), 0x0C (control 1), 0x10 (control 2), 0x14 (control 3) and 0x18 (guard time) read back the last full 32-bit value written. A read of any other offset in the window returns 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 10 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_valid | output | 1 | One-cycle transmit beat |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a full receive buffer while a second byte is offered. The stimulus enables reception, pushes one byte, and then offers more bytes without reading. The bench expects `rx_ready` low and the first byte intact on the next data read. Random traffic mixes small and large status writes, and these can set or clear the receive-full flag directly. The bench model has to follow the flag through those writes as well as through stream handovers and data reads. Control-register writes are biased towards enabling reception, so that the backpressure state occurs often.

// File: rtl/usart_reg_pkg.sv
package usart_reg_pkg;
   localparam int unsigned OFS_STAT  = 'h00;
   localparam int unsigned OFS_DATA  = 'h04;
   localparam int unsigned OFS_BAUD  = 'h08;
   localparam int unsigned OFS_CTL1  = 'h0C;
   localparam int unsigned OFS_CTL2  = 'h10;
   localparam int unsigned OFS_CTL3  = 'h14;
   localparam int unsigned OFS_GUARD = 'h18;

   localparam int unsigned BIT_RXNE = 5;
   localparam int unsigned BIT_TC   = 6;
   localparam int unsigned BIT_TXE  = 7;
   localparam int unsigned BIT_RXEN = 2;
   localparam int unsigned BIT_UEN  = 13;

   localparam logic [31:0] STAT_RST     = 32'h0000_00C0;
   localparam logic [31:0] STAT_REPLACE = 32'h0000_03FF;
   localparam logic [31:0] TX_LIMIT     = 32'h0000_F000;
   localparam logic [31:0] IRQ_SRC      = 32'h0000_00E0;

   typedef enum logic [2:0] {
      SEL_STAT, SEL_DATA, SEL_BAUD, SEL_CTL1,
      SEL_CTL2, SEL_CTL3, SEL_GUARD, SEL_NONE
   } reg_sel_e;

   localparam int unsigned N_PLAIN = 5;
   localparam int unsigned IDX_CTL1 = 1;

   function automatic reg_sel_e plain_sel(input int unsigned idx);
      case (idx)
         0:       return SEL_BAUD;
         1:       return SEL_CTL1;
         2:       return SEL_CTL2;
         3:       return SEL_CTL3;
         default: return SEL_GUARD;
      endcase
   endfunction
endpackage

// File: rtl/usart_addr_dec.sv
module usart_addr_dec
   import usart_reg_pkg::*;
#(
   parameter int unsigned ADDR_W = 10
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_sel_e          sel
);
   always_comb begin
      sel = SEL_NONE;
      if (addr == ADDR_W'(OFS_STAT))       sel = SEL_STAT;
      else if (addr == ADDR_W'(OFS_DATA))  sel = SEL_DATA;
      else if (addr == ADDR_W'(OFS_BAUD))  sel = SEL_BAUD;
      else if (addr == ADDR_W'(OFS_CTL1))  sel = SEL_CTL1;
      else if (addr == ADDR_W'(OFS_CTL2))  sel = SEL_CTL2;
      else if (addr == ADDR_W'(OFS_CTL3))  sel = SEL_CTL3;
      else if (addr == ADDR_W'(OFS_GUARD)) sel = SEL_GUARD;
   end
endmodule

// File: rtl/usart_stat_reg.sv
module usart_stat_reg
   import usart_reg_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          clr_rxne,
   input  logic          set_tc,
   input  logic          set_rxne,
   output logic [DW-1:0] stat_q
);
   localparam logic [DW-1:0] RST_V = DW'(STAT_RST);
   localparam logic [DW-1:0] REPL  = DW'(STAT_REPLACE);

   logic [DW-1:0] stat_d;

   always_comb begin
      stat_d = stat_q;
      if (wr_en) begin
         if (wdata <= REPL) begin
            stat_d          = wdata;
            stat_d[BIT_TXE] = 1'b1;
         end else begin
            stat_d = stat_q & wdata;
         end
      end
      if (clr_rxne) stat_d[BIT_RXNE] = 1'b0;
      if (set_tc)   stat_d[BIT_TC]   = 1'b1;
      if (set_rxne) stat_d[BIT_RXNE] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= RST_V;
      else        stat_q <= stat_d;
   end
endmodule

// File: rtl/usart_rx_gate.sv
module usart_rx_gate #(
   parameter int unsigned RX_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_valid,
   input  logic [RX_W-1:0] rx_data,
   input  logic            full,
   input  logic            port_en,
   input  logic            rx_en,
   output logic            rx_ready,
   output logic            load,
   output logic [RX_W-1:0] data_q
);
   assign rx_ready = !full;
   assign load     = rx_valid && rx_ready && port_en && rx_en;

   always_ff @(posedge clk) begin
      if (!rst_n)    data_q <= '0;
      else if (load) data_q <= rx_data;
   end
endmodule

// File: rtl/usart_tx_beat.sv
module usart_tx_beat #(
   parameter int unsigned TX_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fire,
   input  logic [TX_W-1:0] byte_in,
   output logic            tx_valid,
   output logic [TX_W-1:0] tx_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         tx_valid <= fire;
         if (fire) tx_data <= byte_in;
      end
   end
endmodule

// File: rtl/usart_regfile.sv
module usart_regfile
   import usart_reg_pkg::*;
#(
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned DW      = 32,
   parameter int unsigned CHAR_W  = 8,
   parameter int unsigned RD_KEEP = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   input  logic              bus_rd,
   output logic [DW-1:0]     bus_rdata,
   input  logic              rx_valid,
   input  logic [CHAR_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_data,
   output logic              irq
);
   localparam logic [DW-1:0] RD_MASK  = (DW'(1) << RD_KEEP) - DW'(1);
   localparam logic [DW-1:0] IRQ_MASK = DW'(IRQ_SRC);
   localparam logic [DW-1:0] TX_LIM   = DW'(TX_LIMIT);

   if (ADDR_W < 5)
      begin : g_chk_addr $error("address window too small for the register set"); end
   if (DW < 16)
      begin : g_chk_dw $error("data width must cover the transmit limit"); end
   if (CHAR_W > RD_KEEP || RD_KEEP > DW)
      begin : g_chk_keep $error("read mask must lie between character and bus width"); end

   reg_sel_e          sel;
   logic [DW-1:0]     stat_q;
   logic [CHAR_W-1:0] dr_q;
   logic [DW-1:0]     plain_q [N_PLAIN];
   logic [DW-1:0]     ctl1;
   logic              rx_load;
   logic              dr_read;
   logic              tx_fire;

   usart_addr_dec #(.ADDR_W(ADDR_W)) i_dec (.addr(bus_addr), .sel(sel));

   assign dr_read = bus_rd && (sel == SEL_DATA);
   assign tx_fire = bus_wr && (sel == SEL_DATA) && (bus_wdata < TX_LIM);

   for (genvar gi = 0; gi < N_PLAIN; gi++) begin : g_plain
      localparam reg_sel_e MY_SEL = plain_sel(gi);
      always_ff @(posedge clk) begin
         if (!rst_n)                        plain_q[gi] <= '0;
         else if (bus_wr && sel == MY_SEL)  plain_q[gi] <= bus_wdata;
      end
   end

   assign ctl1 = plain_q[IDX_CTL1];

   usart_stat_reg #(.DW(DW)) i_stat (
      .clk(clk), .rst_n(rst_n),
      .wr_en(bus_wr && sel == SEL_STAT), .wdata(bus_wdata),
      .clr_rxne(dr_read), .set_tc(tx_fire), .set_rxne(rx_load),
      .stat_q(stat_q)
   );

   usart_rx_gate #(.RX_W(CHAR_W)) i_rx (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data),
      .full(stat_q[BIT_RXNE]), .port_en(ctl1[BIT_UEN]), .rx_en(ctl1[BIT_RXEN]),
      .rx_ready(rx_ready), .load(rx_load), .data_q(dr_q)
   );

   usart_tx_beat #(.TX_W(CHAR_W)) i_tx (
      .clk(clk), .rst_n(rst_n),
      .fire(tx_fire), .byte_in(bus_wdata[CHAR_W-1:0]),
      .tx_valid(tx_valid), .tx_data(tx_data)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel == SEL_STAT)      bus_rdata = stat_q;
         else if (sel == SEL_DATA) bus_rdata = DW'(dr_q) & RD_MASK;
         else begin
            for (int i = 0; i < N_PLAIN; i++)
               if (sel == plain_sel(i)) bus_rdata = plain_q[i];
         end
      end
   end

   assign irq = |(stat_q & ctl1 & IRQ_MASK);
endmodule

// File: rtl/usart_regfile_chk.sv
module usart_regfile_chk
   import usart_reg_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DW     = 32,
   parameter int unsigned CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DW-1:0]     bus_wdata,
   input logic              bus_rd,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic              tx_valid,
   input logic [CHAR_W-1:0] tx_data,
   input logic              irq,
   input logic [DW-1:0]     stat_q,
   input logic [CHAR_W-1:0] dr_q,
   input logic [DW-1:0]     ctl1
);
   logic hit_dr, hit_st, en, take;
   assign hit_dr = bus_addr == ADDR_W'(OFS_DATA);
   assign hit_st = bus_addr == ADDR_W'(OFS_STAT);
   assign en     = ctl1[BIT_UEN] && ctl1[BIT_RXEN];
   assign take   = rx_valid && rx_ready;

   AST_IRQ_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      (irq != $past(irq)) |-> $past(bus_wr || bus_rd || take)); // R1
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[BIT_RXNE] && !(bus_rd && hit_dr) && !(bus_wr && hit_st)) |=> $stable(dr_q)); // R2
   AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !en && !bus_wr && !bus_rd) |=> ($stable(stat_q) && $stable(dr_q))); // R3
   AST_RX_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (take && en) |=> stat_q[BIT_RXNE]); // R4
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && hit_dr && !bus_wr && !(take && en)) |=> !stat_q[BIT_RXNE]); // R5
   AST_SMALL_WRITE_TXE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_st && bus_wdata <= DW'(STAT_REPLACE)) |=> stat_q[BIT_TXE]); // R6
   AST_TX_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_dr && bus_wdata < DW'(TX_LIMIT)) |=>
         (tx_valid && tx_data == $past(bus_wdata[CHAR_W-1:0]) && stat_q[BIT_TC])); // R7
   AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && hit_dr && bus_wdata < DW'(TX_LIMIT)) |=> !tx_valid); // R7
endmodule

bind usart_regfile usart_regfile_chk #(.ADDR_W(ADDR_W), .DW(DW), .CHAR_W(CHAR_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rx_valid(rx_valid),
   .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq),
   .stat_q(stat_q), .dr_q(dr_q), .ctl1(ctl1)
);

// File: tb/test_usart_regfile.sv
module test_usart_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_ready, tx_valid, irq;
   logic [7:0]  tx_data;

   always #2 clk = ~clk;

   usart_regfile i_usart_regfile (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [31:0] m_sr = 32'hC0;
   logic [31:0] m_dr = '0;
   logic [31:0] m_plain [8];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] stat_after_write(input logic [31:0] old, input logic [31:0] v);
      return (v <= 32'h3FF) ? (v | 32'h80) : (old & v);
   endfunction

   function automatic logic m_irq();
      return |(m_sr & m_plain[3] & 32'hE0);
   endfunction

   function automatic logic [31:0] model_read(input logic [9:0] a);
      if (a == 10'h00) return m_sr;
      if (a == 10'h04) return m_dr & 32'h3FF;
      if (a >= 10'h08 && a <= 10'h18 && a[1:0] == 2'b00) return m_plain[a[4:2]];
      return 32'h0;
   endfunction

   task automatic do_write(input logic [9:0] a, input logic [31:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 10'h00) m_sr = stat_after_write(m_sr, v);
      else if (a == 10'h04) begin
         if (v < 32'hF000) begin
            chk("R7 beat", {31'd0, tx_valid}, 32'd1);
            chk("R7 byte", {24'd0, tx_data}, {24'd0, v[7:0]});
            m_sr[6] = 1'b1;
         end else chk("R7 ignored", {31'd0, tx_valid}, 32'd0);
      end else if (a >= 10'h08 && a <= 10'h18 && a[1:0] == 2'b00) m_plain[a[4:2]] = v;
      chk("R1 irq", {31'd0, irq}, {31'd0, m_irq()});
   endtask

   task automatic do_read(input logic [9:0] a, input string req);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 chk(req, bus_rdata, model_read(a));
      @(posedge clk);
      @(negedge clk);
      bus_rd = 1'b0;
      if (a == 10'h04) m_sr[5] = 1'b0;
      chk("R1 irq", {31'd0, irq}, {31'd0, m_irq()});
   endtask

   task automatic do_rx(input logic [7:0] b);
      logic took;
      @(negedge clk);
      rx_valid = 1'b1; rx_data = b;
      #1 chk("R2 ready", {31'd0, rx_ready}, {31'd0, !m_sr[5]});
      took = !m_sr[5];
      @(posedge clk);
      @(negedge clk);
      rx_valid = 1'b0;
      if (took && m_plain[3][13] && m_plain[3][2]) begin
         m_dr = {24'd0, b};
         m_sr[5] = 1'b1;
      end
      chk("R1 irq", {31'd0, irq}, {31'd0, m_irq()});
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_plain[i] = '0;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R8 reset state
      #1 chk("R8 irq", {31'd0, irq}, 32'd0);
      chk("R8 tx", {31'd0, tx_valid}, 32'd0);
      for (int a = 0; a <= 'h18; a += 4) do_read(10'(a), "R8 reset read");
      // R3 disabled receive drops
      do_rx(8'h5A);
      do_read(10'h04, "R3 data unchanged");
      do_read(10'h00, "R3 status unchanged");
      // R4 / R2 enabled receive with backpressure
      do_write(10'h0C, 32'h0000_2024);
      do_rx(8'hA7);
      do_read(10'h00, "R4 full flag");
      do_rx(8'h33);
      do_rx(8'h44);
      do_read(10'h04, "R2 R5 first byte kept");
      do_read(10'h00, "R5 flag cleared");
      // R6 status writes
      do_write(10'h00, 32'h0000_0020);
      do_read(10'h00, "R6 small write");
      do_write(10'h00, 32'hFFFF_FF5F);
      do_read(10'h00, "R6 large write");
      // R7 transmit
      do_write(10'h04, 32'h0000_EFC3);
      do_write(10'h04, 32'h0000_F000);
      do_read(10'h00, "R7 done flag");
      // R9 plain storage and undefined offsets
      do_write(10'h08, 32'hDEAD_BEEF);
      do_write(10'h18, 32'h1234_5678);
      do_write(10'h1C, 32'hFFFF_FFFF);
      do_write(10'h3FC, 32'hFFFF_FFFF);
      do_read(10'h08, "R9 baud");
      do_read(10'h18, "R9 guard");
      do_read(10'h1C, "R9 hole");
      do_read(10'h3FC, "R9 top");
      // random mix
      for (int n = 0; n < 600; n++) begin
         int op;
         logic [9:0] a;
         logic [31:0] v;
         op = int'($urandom_range(0, 5));
         a = 10'($urandom_range(0, 8) * 4);
         if ($urandom_range(0, 9) == 0) a = 10'h3FC;
         v = $urandom;
         case (op)
            0: begin
               if (a == 10'h00 && v[0]) v = v & 32'h3FF;
               if (a == 10'h04 && v[1]) v = v & 32'hFFFF;
               if (a == 10'h0C && v[2]) v = v | 32'h2004;
               do_write(a, v);
            end
            1, 2: do_read(a, "R5 R9 random read");
            default: do_rx(8'($urandom));
         endcase
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule